// File: doc/BRIEF.md
# Device-Initiated Transfer Request Handshake

This block sequences a transfer that the device asks the host to perform on one of three channels: out-of-band messaging, bus mastering, or flash access. Software first loads a request register with a byte count, a direction bit and a channel code. For the mastering and flash channels, the byte count includes the address bytes that precede the payload. The block checks the request and, when it is valid, reports the payload length that remains once the address bytes are taken off.

Software then writes a start field. If a valid request is held, this raises a status flag that the host can observe. The block follows the handshake from that point: it notes when the host reads the status, when the host begins the transaction, and when the host finishes it. Software can withdraw the request by clearing the start field, but only until the host has read the status. Once the host has seen it, the transfer always runs to completion.

Both a completed transfer and a successful withdrawal raise a one-cycle event pulse for the interrupt cause logic. A qualifier output tells the two cases apart. Moving the data and running the serial link are handled by other blocks.

Top module: `devreq_handshake`

## Requirements
- R1: After reset, `phase` is 0 (idle), and `stat_flag`, `req_valid`, `req_err`, `evt_pulse` and `evt_cancel` are all 0.
- R2: Channel codes are 0 = out-of-band, 1 = mastering, 2 = flash and 3 = reserved. An accepted request write sets `req_valid` only when all of the following hold: the length is non-zero, the channel is not 3, and for channels 1 and 2 the length exceeds ADDR_BYTES. Otherwise `req_valid` is cleared.
- R3: `payload_len` equals `xfer_len` on channel 0. On channels 1 and 2 it equals `xfer_len` minus ADDR_BYTES.
- R4: Phase codes are 0 idle, 1 pending, 2 seen, 3 active and 4 done. Setting start in phase 0 with `req_valid` high moves the block to phase 1. Setting start with `req_valid` low is ignored. `stat_flag` is high exactly in phases 1 and 2.
- R5: A host status read in phase 1 moves the block to phase 2. A host transaction start in phase 1 or phase 2 moves it to phase 3. If a status read and a transaction start arrive in the same cycle in phase 1, the transaction start wins.
- R6: Clearing start in phase 1, with no host event in the same cycle, returns the block to phase 0 and clears `req_valid`. The next cycle shows `evt_pulse` and `evt_cancel` high for one cycle.
- R7: Clearing start in phase 2 or phase 3 has no effect. If a host status read arrives in the same cycle as a start clear in phase 1, the block goes to phase 2 and no cancel event is raised.
- R8: A request write in phases 1 to 3 leaves the stored request unchanged and sets `req_err`. A request write in phase 0 or phase 4 is accepted and clears `req_err`.
- R9: A host completion in phase 3 moves the block to phase 4 and clears `req_valid`. It raises `evt_pulse` for exactly one cycle, with `evt_cancel` low.
- R10: A request write in phase 4 returns the block to phase 0. Setting start in phase 4 without a new request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Software write strobe for the request register |
| req_len | input | LEN_W | Byte count being written (includes address bytes on channels 1 and 2) |
| req_dir | input | 1 | Direction being written |
| req_chan | input | 2 | Channel code being written |
| start_wr | input | 1 | Software write strobe for the start field |
| start_val | input | 1 | Value written to the start field |
| host_stat_rd | input | 1 | Host has read the status |
| host_xfer_start | input | 1 | Host has begun the transaction |
| host_xfer_done | input | 1 | Host has completed the transaction |
| phase | output | 3 | Current handshake phase |
| stat_flag | output | 1 | Host-visible status flag for a pending request |
| xfer_len | output | LEN_W | Stored byte count |
| payload_len | output | LEN_W | Stored byte count without the address bytes |
| xfer_dir | output | 1 | Stored direction |
| xfer_chan | output | 2 | Stored channel code |
| req_valid | output | 1 | Stored request is valid and not yet consumed |
| req_err | output | 1 | A request write was refused during a transfer |
| evt_pulse | output | 1 | One-cycle completion or cancellation event |
| evt_cancel | output | 1 | Qualifies `evt_pulse` as a cancellation |

## Verification
The bench builds the block with LEN_W = 4 and ADDR_BYTES = 2. At these sizes it can sweep every length, every channel code and both directions, so the validity boundary at and just above the address byte count is covered in full. Each valid request in the sweep is started and then cancelled, which checks the payload subtraction, the pending flag and the cancel pulse on every valid combination. Directed sequences then cover the phases after the host has seen the status. These include the same-cycle races, refused request writes and completion.

// File: rtl/devreq_pkg.sv
package devreq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_PEND = 3'd1,
      PH_SEEN = 3'd2,
      PH_ACTV = 3'd3,
      PH_DONE = 3'd4
   } phase_t;

   typedef enum logic [1:0] {
      CH_OOB   = 2'd0,
      CH_MAST  = 2'd1,
      CH_FLASH = 2'd2,
      CH_RSVD  = 2'd3
   } chan_t;

endpackage

// File: rtl/devreq_regfile.sv
module devreq_regfile
   import devreq_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int ADDR_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [LEN_W-1:0] wr_len,
   input  logic             wr_dir,
   input  logic [1:0]       wr_chan,
   input  logic             accept,
   input  logic             consume,
   output logic [LEN_W-1:0] len_q,
   output logic             dir_q,
   output logic [1:0]       chan_q,
   output logic             valid_q,
   output logic             err_q,
   output logic [LEN_W-1:0] payload
);

   localparam logic [LEN_W-1:0] ADDR_CNT = LEN_W'(ADDR_BYTES);

   logic wr_ok;
   logic is_addr_chan_wr;
   logic is_addr_chan_q;

   assign is_addr_chan_wr = (wr_chan == CH_MAST) || (wr_chan == CH_FLASH);
   assign is_addr_chan_q  = (chan_q == CH_MAST)  || (chan_q == CH_FLASH);

   generate
      if (ADDR_BYTES == 0) begin : g_noaddr
         assign wr_ok   = (wr_len != '0) && (wr_chan != CH_RSVD);
         assign payload = len_q;
      end else begin : g_addr
         assign wr_ok   = (wr_len != '0) && (wr_chan != CH_RSVD) &&
                          (!is_addr_chan_wr || (wr_len > ADDR_CNT));
         assign payload = is_addr_chan_q ? (len_q - ADDR_CNT) : len_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q   <= '0;
         dir_q   <= 1'b0;
         chan_q  <= 2'd0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (wr && accept) begin
            len_q   <= wr_len;
            dir_q   <= wr_dir;
            chan_q  <= wr_chan;
            valid_q <= wr_ok;
            err_q   <= 1'b0;
         end else begin
            if (wr) err_q <= 1'b1;
            if (consume) valid_q <= 1'b0;
         end
      end
   end

   AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !accept) |=> ($stable(len_q) && $stable(chan_q) && err_q)); // R8

   AST_VALID_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && is_addr_chan_q) |-> (len_q > ADDR_CNT)); // R2

endmodule

// File: rtl/devreq_fsm.sv
module devreq_fsm
   import devreq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_wr,
   input  logic   start_val,
   input  logic   stat_rd,
   input  logic   xfer_start,
   input  logic   xfer_done,
   input  logic   req_wr,
   input  logic   req_valid,
   output phase_t phase,
   output logic   req_accept,
   output logic   consume,
   output logic   evt_pulse,
   output logic   evt_cancel
);

   phase_t nxt;
   logic   do_cancel;
   logic   do_done;
   logic   start_set;
   logic   start_clr;

   assign start_set  = start_wr && start_val;
   assign start_clr  = start_wr && !start_val;
   assign req_accept = (phase == PH_IDLE) || (phase == PH_DONE);

   always_comb begin
      nxt       = phase;
      do_cancel = 1'b0;
      do_done   = 1'b0;
      unique case (phase)
         PH_IDLE: if (start_set && req_valid) nxt = PH_PEND;
         PH_PEND: begin
            if (xfer_start)     nxt = PH_ACTV;
            else if (stat_rd)   nxt = PH_SEEN;
            else if (start_clr) begin
               nxt       = PH_IDLE;
               do_cancel = 1'b1;
            end
         end
         PH_SEEN: if (xfer_start) nxt = PH_ACTV;
         PH_ACTV: if (xfer_done) begin
            nxt     = PH_DONE;
            do_done = 1'b1;
         end
         PH_DONE: if (req_wr) nxt = PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
   end

   assign consume = do_cancel || do_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         evt_pulse  <= 1'b0;
         evt_cancel <= 1'b0;
      end else begin
         phase      <= nxt;
         evt_pulse  <= do_cancel || do_done;
         evt_cancel <= do_cancel;
      end
   end

   AST_CANCEL_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      evt_cancel |-> ($past(phase) == PH_PEND && phase == PH_IDLE)); // R6

   AST_DONE_FROM_ACTV: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse && !evt_cancel) |-> ($past(phase) == PH_ACTV && phase == PH_DONE)); // R9

   AST_SEEN_NO_BACKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SEEN) |=> (phase == PH_SEEN || phase == PH_ACTV)); // R7

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |=> !evt_pulse); // R9

   AST_PEND_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PEND && $past(phase) == PH_IDLE) |-> $past(req_valid)); // R4

endmodule

// File: rtl/devreq_handshake.sv
module devreq_handshake
   import devreq_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int ADDR_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_wr,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_dir,
   input  logic [1:0]       req_chan,
   input  logic             start_wr,
   input  logic             start_val,
   input  logic             host_stat_rd,
   input  logic             host_xfer_start,
   input  logic             host_xfer_done,
   output logic [2:0]       phase,
   output logic             stat_flag,
   output logic [LEN_W-1:0] xfer_len,
   output logic [LEN_W-1:0] payload_len,
   output logic             xfer_dir,
   output logic [1:0]       xfer_chan,
   output logic             req_valid,
   output logic             req_err,
   output logic             evt_pulse,
   output logic             evt_cancel
);

   generate
      if (LEN_W < 2) begin : g_bad_width
         $error("LEN_W must be at least 2");
      end
      if (ADDR_BYTES < 0 || ADDR_BYTES >= (1 << LEN_W) - 1) begin : g_bad_addr
         $error("ADDR_BYTES must leave room for at least one payload byte");
      end
   endgenerate

   phase_t ph;
   logic   accept;
   logic   consume;

   devreq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_wr   (start_wr),
      .start_val  (start_val),
      .stat_rd    (host_stat_rd),
      .xfer_start (host_xfer_start),
      .xfer_done  (host_xfer_done),
      .req_wr     (req_wr),
      .req_valid  (req_valid),
      .phase      (ph),
      .req_accept (accept),
      .consume    (consume),
      .evt_pulse  (evt_pulse),
      .evt_cancel (evt_cancel)
   );

   devreq_regfile #(
      .LEN_W      (LEN_W),
      .ADDR_BYTES (ADDR_BYTES)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (req_wr),
      .wr_len  (req_len),
      .wr_dir  (req_dir),
      .wr_chan (req_chan),
      .accept  (accept),
      .consume (consume),
      .len_q   (xfer_len),
      .dir_q   (xfer_dir),
      .chan_q  (xfer_chan),
      .valid_q (req_valid),
      .err_q   (req_err),
      .payload (payload_len)
   );

   assign phase     = ph;
   assign stat_flag = (ph == PH_PEND) || (ph == PH_SEEN);

   AST_FLAG_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      stat_flag |-> req_valid); // R4

endmodule

// File: tb/devreq_handshake_tb.sv
module devreq_handshake_tb;

   localparam int LEN_W = 4;
   localparam int AB    = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_wr = 1'b0;
   logic [LEN_W-1:0] req_len = '0;
   logic             req_dir = 1'b0;
   logic [1:0]       req_chan = 2'd0;
   logic             start_wr = 1'b0;
   logic             start_val = 1'b0;
   logic             host_stat_rd = 1'b0;
   logic             host_xfer_start = 1'b0;
   logic             host_xfer_done = 1'b0;
   logic [2:0]       phase;
   logic             stat_flag;
   logic [LEN_W-1:0] xfer_len;
   logic [LEN_W-1:0] payload_len;
   logic             xfer_dir;
   logic [1:0]       xfer_chan;
   logic             req_valid;
   logic             req_err;
   logic             evt_pulse;
   logic             evt_cancel;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   devreq_handshake #(.LEN_W(LEN_W), .ADDR_BYTES(AB)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_len(req_len),
      .req_dir(req_dir), .req_chan(req_chan), .start_wr(start_wr),
      .start_val(start_val), .host_stat_rd(host_stat_rd),
      .host_xfer_start(host_xfer_start), .host_xfer_done(host_xfer_done),
      .phase(phase), .stat_flag(stat_flag), .xfer_len(xfer_len),
      .payload_len(payload_len), .xfer_dir(xfer_dir), .xfer_chan(xfer_chan),
      .req_valid(req_valid), .req_err(req_err), .evt_pulse(evt_pulse),
      .evt_cancel(evt_cancel)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic ceq(input string tag, input int act, input int exp);
      check(act == exp, tag, act, exp);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      req_wr = 0; start_wr = 0; host_stat_rd = 0;
      host_xfer_start = 0; host_xfer_done = 0;
   endtask

   task automatic wr_req(input int len, input bit dir, input int ch);
      req_wr = 1; req_len = LEN_W'(len); req_dir = dir; req_chan = 2'(ch);
      tick();
   endtask

   task automatic wr_start(input bit v);
      start_wr = 1; start_val = v;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      ceq("R1 phase", phase, 0);
      ceq("R1 stat_flag", stat_flag, 0);
      ceq("R1 req_valid", req_valid, 0);
      ceq("R1 req_err", req_err, 0);
      ceq("R1 evt_pulse", evt_pulse, 0);
      ceq("R1 evt_cancel", evt_cancel, 0);

      // Sweep: R2 validity, R3 payload, R4 start, R6 cancel
      for (int c = 0; c < 4; c++) begin
         for (int d = 0; d < 2; d++) begin
            for (int l = 0; l < (1 << LEN_W); l++) begin
               bit ok;
               int pay;
               ok  = (l != 0) && (c != 3) && (c == 0 || l > AB);
               pay = (c == 0) ? l : l - AB;
               wr_req(l, d[0], c);
               ceq("R2 req_valid", req_valid, int'(ok));
               ceq("R2 xfer_len", xfer_len, l);
               wr_start(1'b1);
               if (ok) begin
                  ceq("R3 payload_len", payload_len, pay);
                  ceq("R4 phase pending", phase, 1);
                  ceq("R4 stat_flag", stat_flag, 1);
                  wr_start(1'b0);
                  ceq("R6 phase idle", phase, 0);
                  ceq("R6 evt_pulse", evt_pulse, 1);
                  ceq("R6 evt_cancel", evt_cancel, 1);
                  ceq("R6 req_valid", req_valid, 0);
                  tick();
                  ceq("R6 pulse one cycle", evt_pulse, 0);
               end else begin
                  ceq("R4 ignored phase", phase, 0);
                  ceq("R4 ignored flag", stat_flag, 0);
               end
            end
         end
      end

      // Seen path: R5, R7, R8, R9
      wr_req(7, 1'b1, 1);
      wr_start(1'b1);
      host_stat_rd = 1; tick();
      ceq("R5 seen", phase, 2);
      ceq("R4 flag in seen", stat_flag, 1);
      wr_start(1'b0);
      ceq("R7 clear ignored in seen", phase, 2);
      ceq("R7 no event", evt_pulse, 0);
      wr_req(3, 1'b0, 0);
      ceq("R8 err set", req_err, 1);
      ceq("R8 len kept", xfer_len, 7);
      ceq("R8 chan kept", xfer_chan, 1);
      host_xfer_start = 1; tick();
      ceq("R5 active", phase, 3);
      ceq("R4 flag low in active", stat_flag, 0);
      wr_start(1'b0);
      ceq("R7 clear ignored in active", phase, 3);
      ceq("R7 valid kept", req_valid, 1);
      host_xfer_done = 1; tick();
      ceq("R9 done", phase, 4);
      ceq("R9 evt_pulse", evt_pulse, 1);
      ceq("R9 evt_cancel", evt_cancel, 0);
      ceq("R9 valid cleared", req_valid, 0);
      tick();
      ceq("R9 pulse one cycle", evt_pulse, 0);

      // R10
      wr_start(1'b1);
      ceq("R10 start ignored in done", phase, 4);
      wr_req(5, 1'b0, 2);
      ceq("R10 back to idle", phase, 0);
      ceq("R8 err cleared", req_err, 0);
      ceq("R3 flash payload", payload_len, 3);

      // R7 race: status read with clear in pending
      wr_start(1'b1);
      host_stat_rd = 1; start_wr = 1; start_val = 0; tick();
      ceq("R7 race seen", phase, 2);
      ceq("R7 race no cancel", evt_cancel, 0);
      host_xfer_start = 1; tick();
      host_xfer_done = 1; tick();
      ceq("R9 done again", phase, 4);

      // R5 host start directly from pending, and start/read race
      wr_req(4, 1'b0, 0);
      wr_start(1'b1);
      host_xfer_start = 1; host_stat_rd = 1; tick();
      ceq("R5 pending to active", phase, 3);
      wr_req(2, 1'b0, 0);
      ceq("R8 err in active", req_err, 1);
      host_xfer_done = 1; tick();
      ceq("R9 final done", phase, 4);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule